// File: doc/BRIEF.md
# USB Type-C Source Attach Detector

This block is the attach and detach engine of a Type-C port acting as a power source. Every clock it receives a classification of each CC pin, already made by the analog front end (open, active-cable termination Ra, or sink termination Rd), plus one comparator flag per pin saying that the pin voltage sits above the disconnect threshold. From the pair of classifications it works out what is plugged in: nothing, a sink in either orientation, a powered cable with or without a sink behind it, or a debug or audio accessory.

It drives the VBUS switch enable, the VCONN enable together with the pin VCONN must go to, the plug orientation, two accessory flags, a flag for a powered cable, a pair of per-pin "watch" outputs telling the front end which pins are being monitored, and a 2-bit current-advertisement select. The front end uses that select to pick the matching disconnect threshold. Firmware places its wanted advertisement level on a static request input, and the block passes it through only while VBUS is on.

An attach must be stable before it takes effect. A detach is accepted only after a monitored pin has stayed above the threshold for the full disconnect time. Both times are parameters counted in clock cycles. The reset input is asynchronous and active low, and its release is synchronised inside the block, which takes two clock edges.

Top module: `typec_src_attach`

## Requirements
- R1: Each CC code is 2 bits: 00 open, 01 Ra, 10 Rd. The code 11 is reserved and is treated exactly like open.
- R2: A new code pair takes effect only at the clock edge on which it has been sampled unchanged for ATTACH_DEB+1 consecutive edges. Any change of the pair in between restarts the count.
- R3: With both pins open, or after reset, VBUS, VCONN, orientation, the accessory flags and the cable flag are all 0, both watch outputs are 1, and the advertisement select is 00.
- R4: Rd on one pin with the other open turns VBUS on and keeps VCONN off. flip is 1 when the Rd pin is CC2. Only the Rd pin's watch output is 1.
- R5: Ra on one pin with the other open raises the cable flag, keeps VBUS and VCONN off and watches both pins. If Rd then appears on the open pin, with Ra unchanged, the R6 state is entered after the R2 debounce. Ra appearing on the other pin has no effect. Only the Ra pin's threshold flag can end this state.
- R6: Ra on one pin with Rd on the other turns on VBUS and VCONN and raises the cable flag. vconn_on_cc2 is 1 when Ra is on CC2, and flip follows the Rd pin. Only the Rd pin is watched, and the Ra pin's threshold flag has no effect.
- R7: Rd on both pins raises dbg_acc, and Ra on both pins raises aud_acc. VBUS and VCONN stay off, both pins are watched, and the threshold flag of either pin can end the connection.
- R8: A detach happens on the clock edge where the threshold flag of a pin that can end the current state has been high on TCC_CYC consecutive edges. A shorter excursion, or a flag on a pin that cannot end the state, changes nothing.
- R9: On the detach edge VBUS, VCONN, the flags and the advertisement select all return to their R3 values together.
- R10: The advertisement select is 00 while VBUS is off and on the edge VBUS turns on. From the following edge it follows the request with one edge of latency: 01 (1.5 A) and 10 (3.0 A) pass through, and 00 or 11 give 00.
- R11: Once a sink, a sink with cable, or an accessory is attached, changes in the CC codes are ignored. Only R8 ends the connection.
- R12: Pulling rst_n low forces the R3 outputs at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cc1_code | input | 2 | Classification of CC1 |
| cc2_code | input | 2 | Classification of CC2 |
| cc1_hi | input | 1 | CC1 above disconnect threshold |
| cc2_hi | input | 1 | CC2 above disconnect threshold |
| rp_req | input | 2 | Firmware advertisement request |
| vbus_en | output | 1 | VBUS switch enable |
| vconn_en | output | 1 | VCONN enable |
| vconn_on_cc2 | output | 1 | VCONN goes to CC2 (else CC1) |
| flip | output | 1 | Sink termination is on CC2 |
| dbg_acc | output | 1 | Debug accessory attached |
| aud_acc | output | 1 | Audio accessory attached |
| cable_ra | output | 1 | Powered cable termination present |
| watch_cc1 | output | 1 | CC1 is being monitored |
| watch_cc2 | output | 1 | CC2 is being monitored |
| rp_sel | output | 2 | Advertisement level to current source and comparator |

## Verification
A wrong connection state shows at the ports on the same edge it is entered, because every enable, flag and watch output decodes directly from the state register. A bad orientation or VCONN pin register shows as the wrong watch output or as VCONN on the terminated sink pin. A counter that is off by one moves the attach or detach edge by a cycle, so the bench samples one edge before and exactly on the required edge. A stuck advertisement register shows one edge after VBUS turns on, or on the detach edge, when the select must already be back at 00.

// File: rtl/typec_src_pkg.sv
package typec_src_pkg;

  localparam logic [1:0] CC_OPEN = 2'b00;
  localparam logic [1:0] CC_RA   = 2'b01;
  localparam logic [1:0] CC_RD   = 2'b10;

  localparam logic [1:0] RP_DEF  = 2'b00;
  localparam logic [1:0] RP_1A5  = 2'b01;
  localparam logic [1:0] RP_3A0  = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SINK   = 3'd1,
    ST_CABLE  = 3'd2,
    ST_SNKCAB = 3'd3,
    ST_DEBUG  = 3'd4,
    ST_AUDIO  = 3'd5
  } conn_st_e;

  // reserved code folds to open
  function automatic logic [1:0] cc_norm(input logic [1:0] code);
    return (code == 2'b11) ? CC_OPEN : code;
  endfunction

  function automatic logic st_has_vbus(input conn_st_e st);
    return (st == ST_SINK) || (st == ST_SNKCAB);
  endfunction

endpackage

// File: rtl/cc_pair_decode.sv
module cc_pair_decode
  import typec_src_pkg::*;
(
  input  logic [1:0] cc1_code,
  input  logic [1:0] cc2_code,
  output logic [3:0] pair_n,
  output conn_st_e   kind,
  output logic       rd_on_cc2,
  output logic       ra_on_cc2
);

  logic [1:0] n1;
  logic [1:0] n2;

  assign n1     = cc_norm(cc1_code);
  assign n2     = cc_norm(cc2_code);
  assign pair_n = {n1, n2};

  // lone Rd / lone Ra pin position
  assign rd_on_cc2 = (n2 == CC_RD) && (n1 != CC_RD);
  assign ra_on_cc2 = (n2 == CC_RA) && (n1 != CC_RA);

  always_comb begin
    kind = ST_IDLE;
    unique case ({n1, n2})
      {CC_RD, CC_OPEN}, {CC_OPEN, CC_RD}: kind = ST_SINK;
      {CC_RA, CC_OPEN}, {CC_OPEN, CC_RA}: kind = ST_CABLE;
      {CC_RA, CC_RD},   {CC_RD, CC_RA}:   kind = ST_SNKCAB;
      {CC_RD, CC_RD}:                     kind = ST_DEBUG;
      {CC_RA, CC_RA}:                     kind = ST_AUDIO;
      default:                            kind = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/run_counter.sv
module run_counter #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic hold,
  output logic done
);

  localparam int             CW   = $clog2(LIMIT + 1);
  localparam logic [CW-1:0]  LAST = CW'(LIMIT - 1);
  localparam logic [CW-1:0]  SAT  = CW'(LIMIT);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  // done on the LIMIT-th consecutive held edge
  assign done = hold && (cnt_q >= LAST);

  always_comb begin
    if (clr || !hold) begin
      cnt_d = '0;
    end else if (cnt_q != SAT) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_d = cnt_q;
    end
  end

  assign cnt_en = (cnt_d != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/typec_src_fsm.sv
module typec_src_fsm
  import typec_src_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  conn_st_e kind,
  input  logic     rd_on_cc2,
  input  logic     ra_on_cc2,
  input  logic     cc1_hi,
  input  logic     cc2_hi,
  input  logic     attach_done,
  input  logic     detach_done,
  output conn_st_e state_q,
  output conn_st_e state_d,
  output logic     rd_pin_q,
  output logic     ra_pin_q,
  output logic     attach_elig,
  output logic     detach_cond,
  output logic     change
);

  logic rd_pin_d;
  logic ra_pin_d;
  logic det1;
  logic det2;
  logic st_en;

  // which states may still accept a new attach
  always_comb begin
    attach_elig = 1'b0;
    unique case (state_q)
      ST_IDLE:  attach_elig = (kind != ST_IDLE);
      ST_CABLE: attach_elig = (kind == ST_SNKCAB) && (ra_on_cc2 == ra_pin_q);
      default:  attach_elig = 1'b0;
    endcase
  end

  // pins whose threshold flag can end the current state
  always_comb begin
    det1 = 1'b0;
    det2 = 1'b0;
    unique case (state_q)
      ST_SINK, ST_SNKCAB: begin
        det1 = ~rd_pin_q;
        det2 = rd_pin_q;
      end
      ST_CABLE: begin
        det1 = ~ra_pin_q;
        det2 = ra_pin_q;
      end
      ST_DEBUG, ST_AUDIO: begin
        det1 = 1'b1;
        det2 = 1'b1;
      end
      default: begin
        det1 = 1'b0;
        det2 = 1'b0;
      end
    endcase
  end

  assign detach_cond = (det1 & cc1_hi) | (det2 & cc2_hi);

  always_comb begin
    state_d  = state_q;
    rd_pin_d = rd_pin_q;
    ra_pin_d = ra_pin_q;
    if (detach_done) begin
      state_d  = ST_IDLE;
      rd_pin_d = 1'b0;
      ra_pin_d = 1'b0;
    end else if (attach_done) begin
      state_d  = kind;
      rd_pin_d = rd_on_cc2;
      ra_pin_d = ra_on_cc2;
    end
  end

  assign change = (state_d != state_q);
  assign st_en  = change || (rd_pin_d != rd_pin_q) || (ra_pin_d != ra_pin_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      rd_pin_q <= 1'b0;
      ra_pin_q <= 1'b0;
    end else if (st_en) begin
      state_q  <= state_d;
      rd_pin_q <= rd_pin_d;
      ra_pin_q <= ra_pin_d;
    end
  end

endmodule

// File: rtl/typec_src_out.sv
module typec_src_out
  import typec_src_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  conn_st_e   state_q,
  input  conn_st_e   state_d,
  input  logic       rd_pin_q,
  input  logic       ra_pin_q,
  input  logic [1:0] rp_req,
  output logic       vbus_en,
  output logic       vconn_en,
  output logic       vconn_on_cc2,
  output logic       flip,
  output logic       dbg_acc,
  output logic       aud_acc,
  output logic       cable_ra,
  output logic       watch_cc1,
  output logic       watch_cc2,
  output logic [1:0] rp_sel
);

  logic [1:0] rp_q;
  logic [1:0] rp_d;
  logic [1:0] rp_map;
  logic       rp_en;

  assign vbus_en      = st_has_vbus(state_q);
  assign vconn_en     = (state_q == ST_SNKCAB);
  assign vconn_on_cc2 = vconn_en & ra_pin_q;
  assign flip         = vbus_en & rd_pin_q;
  assign dbg_acc      = (state_q == ST_DEBUG);
  assign aud_acc      = (state_q == ST_AUDIO);
  assign cable_ra     = (state_q == ST_CABLE) || (state_q == ST_SNKCAB);
  assign watch_cc1    = vbus_en ? ~rd_pin_q : 1'b1;
  assign watch_cc2    = vbus_en ? rd_pin_q  : 1'b1;

  always_comb begin
    unique case (rp_req)
      RP_1A5:  rp_map = RP_1A5;
      RP_3A0:  rp_map = RP_3A0;
      default: rp_map = RP_DEF;
    endcase
  end

  // raised only once VBUS has been on for an edge, dropped with it
  assign rp_d  = (st_has_vbus(state_q) && st_has_vbus(state_d)) ? rp_map : RP_DEF;
  assign rp_en = (rp_d != rp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp_q <= RP_DEF;
    end else if (rp_en) begin
      rp_q <= rp_d;
    end
  end

  assign rp_sel = rp_q;

endmodule

// File: rtl/typec_src_attach.sv
module typec_src_attach
  import typec_src_pkg::*;
#(
  parameter int ATTACH_DEB = 16,
  parameter int TCC_CYC    = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cc1_code,
  input  logic [1:0] cc2_code,
  input  logic       cc1_hi,
  input  logic       cc2_hi,
  input  logic [1:0] rp_req,
  output logic       vbus_en,
  output logic       vconn_en,
  output logic       vconn_on_cc2,
  output logic       flip,
  output logic       dbg_acc,
  output logic       aud_acc,
  output logic       cable_ra,
  output logic       watch_cc1,
  output logic       watch_cc2,
  output logic [1:0] rp_sel
);

  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  core_rst_n;

  logic [3:0] pair_n;
  logic [3:0] cand_q;
  logic       cand_en;
  conn_st_e   kind;
  logic       rd_on_cc2;
  logic       ra_on_cc2;
  conn_st_e   state_q;
  conn_st_e   state_d;
  logic       rd_pin_q;
  logic       ra_pin_q;
  logic       attach_elig;
  logic       detach_cond;
  logic       change;
  logic       attach_hold;
  logic       attach_done;
  logic       detach_done;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
    end
  end
  assign core_rst_n = rst_pipe_q[RST_STAGES-1];

  cc_pair_decode u_dec (
    .cc1_code  (cc1_code),
    .cc2_code  (cc2_code),
    .pair_n    (pair_n),
    .kind      (kind),
    .rd_on_cc2 (rd_on_cc2),
    .ra_on_cc2 (ra_on_cc2)
  );

  // previous sampled pair: equality means "unchanged since last edge"
  assign cand_en = (pair_n != cand_q);
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      cand_q <= '0;
    end else if (cand_en) begin
      cand_q <= pair_n;
    end
  end

  assign attach_hold = attach_elig && (pair_n == cand_q);

  run_counter #(.LIMIT(ATTACH_DEB)) u_att_cnt (
    .clk   (clk),
    .rst_n (core_rst_n),
    .clr   (change),
    .hold  (attach_hold),
    .done  (attach_done)
  );

  run_counter #(.LIMIT(TCC_CYC)) u_det_cnt (
    .clk   (clk),
    .rst_n (core_rst_n),
    .clr   (change),
    .hold  (detach_cond),
    .done  (detach_done)
  );

  typec_src_fsm u_fsm (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .kind        (kind),
    .rd_on_cc2   (rd_on_cc2),
    .ra_on_cc2   (ra_on_cc2),
    .cc1_hi      (cc1_hi),
    .cc2_hi      (cc2_hi),
    .attach_done (attach_done),
    .detach_done (detach_done),
    .state_q     (state_q),
    .state_d     (state_d),
    .rd_pin_q    (rd_pin_q),
    .ra_pin_q    (ra_pin_q),
    .attach_elig (attach_elig),
    .detach_cond (detach_cond),
    .change      (change)
  );

  typec_src_out u_out (
    .clk          (clk),
    .rst_n        (core_rst_n),
    .state_q      (state_q),
    .state_d      (state_d),
    .rd_pin_q     (rd_pin_q),
    .ra_pin_q     (ra_pin_q),
    .rp_req       (rp_req),
    .vbus_en      (vbus_en),
    .vconn_en     (vconn_en),
    .vconn_on_cc2 (vconn_on_cc2),
    .flip         (flip),
    .dbg_acc      (dbg_acc),
    .aud_acc      (aud_acc),
    .cable_ra     (cable_ra),
    .watch_cc1    (watch_cc1),
    .watch_cc2    (watch_cc2),
    .rp_sel       (rp_sel)
  );

endmodule

// File: rtl/typec_src_attach_chk.sv
module typec_src_attach_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cc1_hi,
  input logic       cc2_hi,
  input logic       vbus_en,
  input logic       vconn_en,
  input logic       vconn_on_cc2,
  input logic       flip,
  input logic       dbg_acc,
  input logic       aud_acc,
  input logic       cable_ra,
  input logic       watch_cc1,
  input logic       watch_cc2,
  input logic [1:0] rp_sel
);

  // R6: VCONN only together with VBUS and a cable
  p_vconn_needs_vbus_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vconn_en |-> (vbus_en && cable_ra));

  // R6: VCONN never lands on the sink pin
  p_vconn_pin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vconn_en |-> (vconn_on_cc2 != flip));

  // R7: accessories exclude VBUS and each other
  p_acc_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dbg_acc, aud_acc, vbus_en}));

  // R7: accessories keep both pins monitored
  p_acc_watch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_acc || aud_acc) |-> (watch_cc1 && watch_cc2));

  // R4: with VBUS on exactly one pin is monitored
  p_single_watch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vbus_en |-> ($countones({watch_cc1, watch_cc2}) == 1));

  // R10: raised advertisement only after VBUS has been on an edge
  p_rp_default_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rp_sel != 2'b00) |-> (vbus_en && $past(vbus_en)));

  // R10: reserved advertisement code never driven
  p_rp_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rp_sel != 2'b11);

  // R9: everything returns to idle on the detach edge
  p_detach_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vbus_en) |-> ((rp_sel == 2'b00) && !vconn_en && watch_cc1 && watch_cc2));

  // R8: VBUS drops only after a threshold flag was high
  p_detach_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vbus_en) |-> $past(cc1_hi || cc2_hi));

endmodule

bind typec_src_attach typec_src_attach_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cc1_hi       (cc1_hi),
  .cc2_hi       (cc2_hi),
  .vbus_en      (vbus_en),
  .vconn_en     (vconn_en),
  .vconn_on_cc2 (vconn_on_cc2),
  .flip         (flip),
  .dbg_acc      (dbg_acc),
  .aud_acc      (aud_acc),
  .cable_ra     (cable_ra),
  .watch_cc1    (watch_cc1),
  .watch_cc2    (watch_cc2),
  .rp_sel       (rp_sel)
);

// File: tb/typec_src_attach_test.sv
module typec_src_attach_test;

  localparam int ATT = 3;
  localparam int TCC = 5;
  localparam logic [8:0] IDLE_BUS = 9'b000000011;

  logic       clk;
  logic       rst_n;
  logic [1:0] cc1_code;
  logic [1:0] cc2_code;
  logic       cc1_hi;
  logic       cc2_hi;
  logic [1:0] rp_req;
  logic       vbus_en, vconn_en, vconn_on_cc2, flip;
  logic       dbg_acc, aud_acc, cable_ra, watch_cc1, watch_cc2;
  logic [1:0] rp_sel;
  logic [8:0] obs;

  int checks;
  int errors;
  bit finished;

  typec_src_attach #(.ATTACH_DEB(ATT), .TCC_CYC(TCC)) uut (
    .clk (clk), .rst_n (rst_n),
    .cc1_code (cc1_code), .cc2_code (cc2_code),
    .cc1_hi (cc1_hi), .cc2_hi (cc2_hi), .rp_req (rp_req),
    .vbus_en (vbus_en), .vconn_en (vconn_en), .vconn_on_cc2 (vconn_on_cc2),
    .flip (flip), .dbg_acc (dbg_acc), .aud_acc (aud_acc), .cable_ra (cable_ra),
    .watch_cc1 (watch_cc1), .watch_cc2 (watch_cc2), .rp_sel (rp_sel)
  );

  assign obs = {vbus_en, vconn_en, vconn_on_cc2, flip, dbg_acc, aud_acc,
                cable_ra, watch_cc1, watch_cc2};

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [1:0] nrm(input logic [1:0] c);
    return (c == 2'b11) ? 2'b00 : c;
  endfunction

  // 0 idle 1 sink 2 cable 3 sink+cable 4 debug 5 audio
  function automatic int kind_of(input logic [1:0] a, input logic [1:0] b);
    logic [1:0] x = nrm(a);
    logic [1:0] y = nrm(b);
    int nrd = int'(x == 2'b10) + int'(y == 2'b10);
    int nra = int'(x == 2'b01) + int'(y == 2'b01);
    if (nrd == 2) return 4;
    if (nra == 2) return 5;
    if (nrd == 1 && nra == 1) return 3;
    if (nrd == 1) return 1;
    if (nra == 1) return 2;
    return 0;
  endfunction

  function automatic logic [8:0] exp_bus(input logic [1:0] a, input logic [1:0] b);
    logic f  = (nrm(b) == 2'b10) && (nrm(a) != 2'b10);
    logic r2 = (nrm(b) == 2'b01) && (nrm(a) != 2'b01);
    case (kind_of(a, b))
      1: return {1'b1, 1'b0, 1'b0, f, 1'b0, 1'b0, 1'b0, ~f, f};
      2: return 9'b000000111;
      3: return {1'b1, 1'b1, r2, f, 1'b0, 1'b0, 1'b1, ~f, f};
      4: return 9'b000010011;
      5: return 9'b000001011;
      default: return IDLE_BUS;
    endcase
  endfunction

  function automatic string tag_of(input int k);
    case (k)
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4, 5: return "R7";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, got, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cc1_code = 2'b00; cc2_code = 2'b00;
    cc1_hi = 1'b0; cc2_hi = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(3);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    checks = 0; errors = 0; finished = 1'b0;
    rp_req = 2'b10;
    do_reset();
    // R12 / R3 reset state
    chk("R12 reset outputs", 32'(obs), 32'(IDLE_BUS));
    chk("R3 reset rp", 32'(rp_sel), 32'd0);

    // exhaustive sweep of all code pairs from idle
    for (int p = 0; p < 16; p++) begin
      logic [1:0] a = 2'(p >> 2);
      logic [1:0] b = 2'(p);
      int k = kind_of(a, b);
      string t = ((a == 2'b11) || (b == 2'b11)) ? "R1" : tag_of(k);
      do_reset();
      rp_req = 2'b10;
      cc1_code = a; cc2_code = b;
      tick(ATT);
      chk("R2 before debounce", 32'(obs), 32'(IDLE_BUS));
      tick(1);
      chk(t, 32'(obs), 32'(exp_bus(a, b)));
      if (k == 1 || k == 3) begin
        chk("R10 rp default on vbus edge", 32'(rp_sel), 32'd0);
        tick(1);
        chk("R10 rp follows request", 32'(rp_sel), 32'd2);
      end
      if (k != 0) begin
        logic on2;
        if (k == 1 || k == 3)      on2 = (nrm(b) == 2'b10) && (nrm(a) != 2'b10);
        else if (k == 2)           on2 = (nrm(b) == 2'b01);
        else                       on2 = p[0];
        if (on2) cc2_hi = 1'b1; else cc1_hi = 1'b1;
        tick(TCC - 1);
        chk("R8 held before tCC", 32'(obs), 32'(exp_bus(a, b)));
        tick(1);
        chk("R9 detach outputs", 32'(obs), 32'(IDLE_BUS));
        chk("R9 detach rp", 32'(rp_sel), 32'd0);
        cc1_hi = 1'b0; cc2_hi = 1'b0;
        cc1_code = 2'b00; cc2_code = 2'b00;
        tick(ATT + 2);
      end
    end

    // R2 restart on change, then sink on CC2
    do_reset();
    rp_req = 2'b00;
    cc1_code = 2'b10; cc2_code = 2'b00;
    tick(2);
    cc1_code = 2'b00; cc2_code = 2'b10;
    tick(ATT);
    chk("R2 restart holds idle", 32'(obs), 32'(IDLE_BUS));
    tick(1);
    chk("R2 attach after restart", 32'(obs), 32'(9'b100100001));
    // R8 short excursions ignored
    cc2_hi = 1'b1; tick(TCC - 1);
    cc2_hi = 1'b0; tick(1);
    cc2_hi = 1'b1; tick(TCC - 1);
    chk("R8 short excursion", 32'(vbus_en), 32'd1);
    cc2_hi = 1'b0;
    cc1_hi = 1'b1; tick(2 * TCC);
    chk("R8 unmonitored pin ignored", 32'(obs), 32'(9'b100100001));
    cc1_hi = 1'b0;
    // R11 code changes ignored while attached
    cc1_code = 2'b01; cc2_code = 2'b01; tick(ATT + 3);
    chk("R11 codes ignored", 32'(obs), 32'(9'b100100001));
    cc1_code = 2'b00; cc2_code = 2'b00; tick(ATT + 3);
    chk("R11 open ignored", 32'(obs), 32'(9'b100100001));
    // R10 request mapping
    rp_req = 2'b01; tick(1);
    chk("R10 1.5A", 32'(rp_sel), 32'd1);
    rp_req = 2'b11; tick(1);
    chk("R10 reserved gives default", 32'(rp_sel), 32'd0);
    rp_req = 2'b10; tick(1);
    chk("R10 3.0A", 32'(rp_sel), 32'd2);
    cc2_hi = 1'b1; tick(TCC);
    chk("R9 detach from sink", 32'(obs), 32'(IDLE_BUS));
    chk("R9 rp back to default", 32'(rp_sel), 32'd0);
    cc2_hi = 1'b0; tick(2);

    // R5 cable, wrong-pin Ra ignored, then sink behind cable
    do_reset();
    cc1_code = 2'b00; cc2_code = 2'b01;
    tick(ATT + 1);
    chk("R5 cable only", 32'(obs), 32'(9'b000000111));
    cc1_code = 2'b01; cc2_code = 2'b10;
    tick(ATT + 4);
    chk("R5 moved Ra ignored", 32'(obs), 32'(9'b000000111));
    cc1_hi = 1'b1; tick(2 * TCC);
    chk("R5 open pin flag ignored", 32'(obs), 32'(9'b000000111));
    cc1_hi = 1'b0;
    cc1_code = 2'b10; cc2_code = 2'b01;
    tick(ATT);
    chk("R5 upgrade debounced", 32'(obs), 32'(9'b000000111));
    tick(1);
    chk("R6 sink behind cable", 32'(obs), 32'(9'b111000110));
    cc2_hi = 1'b1; tick(2 * TCC);
    chk("R6 Ra pin flag ignored", 32'(obs), 32'(9'b111000110));
    cc2_hi = 1'b0;
    cc1_hi = 1'b1; tick(TCC);
    chk("R8 detach via Rd pin", 32'(obs), 32'(IDLE_BUS));
    cc1_hi = 1'b0;

    // R12 asynchronous reset while attached
    cc1_code = 2'b10; cc2_code = 2'b00;
    tick(ATT + 3);
    chk("R4 sink on CC1", 32'(obs), 32'(9'b100000010));
    #2 rst_n = 1'b0;
    #1;
    chk("R12 async reset", 32'(obs), 32'(IDLE_BUS));
    chk("R12 async reset rp", 32'(rp_sel), 32'd0);
    tick(1);
    rst_n = 1'b1;
    tick(3);

    finish_run();
  end

endmodule